// File: doc/BRIEF.md
# Low-Speed USB Packet Serialiser

This block sends one short packet onto the differential data pair of a low-speed USB device. A one-cycle start request carries a payload byte count. The block first sets the pair to the idle J level while its drivers are still off, and then turns the drivers on. It sends the synchronisation byte and then the payload bytes, least significant bit first. The bits are NRZI coded and bit-stuffed. The packet closes with a fixed end-of-packet sequence, after which the block releases the bus.

Payload bytes come from a combinational byte-read port: the block presents a byte index and samples the returned byte in the same cycle. The caller supplies finished bytes, such as a PID or data with its CRC already appended, so the block adds no checksum. A single-byte payload forms a handshake reply. The fixed two-clock latency from the start request to the first K level keeps the reply well inside the turnaround limit of 6.5 bit times that applies after a received packet.

Top module: `lsusb_tx`

## Requirements
- R1: While reset is asserted, and afterwards until a start request arrives, `oe` is 0, `done` is 0, `dp` is 0 and `dm` is 1 (the J level).
- R2: A start request sampled while the block is idle produces one clock with `oe`=0 and J on the pair. On the next clock `oe` rises together with the first bit cell.
- R3: The first byte sent is 0x80. It is followed by `byte_cnt` payload bytes, each read at `rd_addr` 0, 1, 2 and so on in turn. Every byte is sent bit 0 first.
- R4: NRZI coding is used. A 0 bit toggles the pair and a 1 bit holds it. While bits are being sent, `dm` is always the inverse of `dp`. The level before the first cell is J (`dp`=0), so the first sync cell is K (`dp`=1).
- R5: After six consecutive 1 bits, one extra cell with a toggled pair is inserted, and the run count then restarts at zero. The run of ones counts across byte boundaries, and a stuff cell is still inserted when the sixth 1 is the last payload bit.
- R6: Every bit cell, stuffed cells included, lasts exactly `BIT_CLKS` clocks.
- R7: After the last cell, both lines are driven low for 2×`BIT_CLKS` clocks. Then J is driven for `BIT_CLKS` clocks, and then `oe` falls.
- R8: `done` is high for exactly one clock, the first clock in which `oe` is low after a packet.
- R9: A start request that arrives while a packet is in progress is ignored. The packet runs unchanged, and no second packet follows it.
- R10: A `byte_cnt` of 0 sends only the sync byte and then the end-of-packet sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to send a packet |
| byte_cnt | input | CNT_W | Number of payload bytes, sampled with `start` |
| rd_addr | output | CNT_W | Index of the payload byte being read |
| rd_data | input | 8 | Payload byte at `rd_addr`, combinational |
| dp | output | 1 | D+ drive value |
| dm | output | 1 | D- drive value |
| oe | output | 1 | Driver enable for the pair |
| done | output | 1 | One-clock pulse when the bus is released |

## Verification
The bench builds the block with `BIT_CLKS`=3 and `CNT_W`=3. The odd bit period exercises the cell and end-of-packet timers away from power-of-two values. The 3-bit count makes the largest payload that a table row can hold cover runs of ones that cross byte boundaries. With packets only a few dozen cells long, the bench can compare every clock of every cell against an independently computed NRZI and stuffing sequence. That sequence includes a stuff cell that falls just before the end-of-packet.

// File: rtl/lsusb_tx.sv
module lsusb_tx #(
  parameter int BIT_CLKS = 8,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_cnt,
  output logic [CNT_W-1:0] rd_addr,
  input  logic [7:0]       rd_data,
  output logic             dp,
  output logic             dm,
  output logic             oe,
  output logic             done
);
  localparam int TW = $clog2(2 * BIT_CLKS);
  localparam logic [TW-1:0] CELL_END = TW'(BIT_CLKS - 1);
  localparam logic [TW-1:0] EOP_END  = TW'(2 * BIT_CLKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_DATA, S_SE0, S_J} st_t;

  st_t             st;
  logic [TW-1:0]   tmr;
  logic [7:0]      sreg;
  logic [2:0]      bpos;
  logic [2:0]      ones;
  logic            stuff, more;
  logic [CNT_W-1:0] nb, idx;

  wire adv = (st == S_PREP) || (st == S_DATA && tmr == CELL_END);
  assign rd_addr = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; sreg <= '0; bpos <= '0; ones <= '0;
      stuff <= 1'b0; more <= 1'b0; nb <= '0; idx <= '0;
      dp <= 1'b0; dm <= 1'b1; oe <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_PREP; nb <= byte_cnt; idx <= '0; sreg <= 8'h80;
          bpos <= '0; ones <= '0; stuff <= 1'b0; more <= 1'b1;
          dp <= 1'b0; dm <= 1'b1;
        end
        S_SE0: begin
          tmr <= tmr + 1'b1;
          if (tmr == EOP_END) begin st <= S_J; dm <= 1'b1; tmr <= '0; end
        end
        S_J: begin
          tmr <= tmr + 1'b1;
          if (tmr == CELL_END) begin st <= S_IDLE; oe <= 1'b0; done <= 1'b1; tmr <= '0; end
        end
        default: begin
          tmr <= tmr + 1'b1;
          if (adv) begin
            tmr <= '0;
            oe  <= 1'b1;
            if (stuff) begin
              dp <= ~dp; dm <= dp; stuff <= 1'b0; ones <= '0;
            end else if (more) begin
              st <= S_DATA;
              if (!sreg[0]) begin dp <= ~dp; dm <= dp; end
              ones  <= sreg[0] ? ones + 1'b1 : '0;
              stuff <= sreg[0] && ones == 3'd5;
              if (bpos == 3'd7) begin
                bpos <= '0;
                if (idx != nb) begin sreg <= rd_data; idx <= idx + 1'b1; end
                else more <= 1'b0;
              end else begin
                bpos <= bpos + 1'b1; sreg <= sreg >> 1;
              end
            end else begin
              st <= S_SE0; dp <= 1'b0; dm <= 1'b0;
            end
          end
        end
      endcase
    end
  end

  a_r1_j_before_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $past(!dp && dm));
  a_r2_enable_follows_prep: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PREP) |=> oe);
  a_r4_pair_complementary: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> (dm == !dp));
  a_r6_cell_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && tmr != '0) |-> ($stable(dp) && $stable(dm)));
  a_r7_release_from_j: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> $past(oe && !dp && dm));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> done);
  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start) |=> (st != S_PREP));
endmodule

// File: tb/lsusb_tx_tb.sv
module lsusb_tx_tb;
  localparam int B  = 3;
  localparam int CW = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CW-1:0] byte_cnt = '0, rd_addr;
  logic [7:0] rd_data;
  logic dp, dm, oe, done;
  logic [7:0] mem [0:7];
  int checks = 0, errors = 0;
  bit exp_lvl [0:255];
  int ncell;

  always #5 clk = ~clk;
  assign rd_data = mem[rd_addr];

  lsusb_tx #(.BIT_CLKS(B), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt),
    .rd_addr(rd_addr), .rd_data(rd_data), .dp(dp), .dm(dm), .oe(oe), .done(done));

  // {count, byte0, byte1, byte2, byte3}
  localparam logic [39:0] VEC [0:5] = '{
    {8'd1, 8'hD2, 8'h00, 8'h00, 8'h00},
    {8'd0, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'd2, 8'hFF, 8'hFF, 8'h00, 8'h00},
    {8'd3, 8'h7E, 8'h3F, 8'h00, 8'h00},
    {8'd1, 8'hFC, 8'h00, 8'h00, 8'h00},
    {8'd4, 8'h01, 8'h80, 8'hAA, 8'h55}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic build(input int n, input logic [31:0] b);
    bit lvl = 1'b0;
    int ones = 0;
    ncell = 0;
    for (int j = 0; j <= n; j++) begin
      logic [7:0] v = (j == 0) ? 8'h80 : b[39 - 8*j -: 8];
      for (int k = 0; k < 8; k++) begin
        if (!v[k]) lvl = ~lvl;
        exp_lvl[ncell] = lvl; ncell++;
        ones = v[k] ? ones + 1 : 0;
        if (ones == 6) begin lvl = ~lvl; exp_lvl[ncell] = lvl; ncell++; ones = 0; end
      end
    end
  endtask

  task automatic run_case(input int n, input logic [31:0] b, input bit inject, input string tag);
    bit ok;
    for (int i = 0; i < 4; i++) mem[i] = b[31 - 8*i -: 8];
    build(n, b);
    @(negedge clk); start = 1'b1; byte_cnt = CW'(n);
    @(negedge clk); start = 1'b0;
    check(!oe && !dp && dm, {"R2 prep J with oe low ", tag}, {oe, dp, dm}, 3'b001);
    for (int i = 0; i < ncell; i++) begin
      ok = 1'b1;
      for (int c = 0; c < B; c++) begin
        @(negedge clk);
        start = inject && i == 3 && c == 0;
        byte_cnt = 3'd7;
        if (!(oe && dp == exp_lvl[i] && dm == !exp_lvl[i])) ok = 1'b0;
      end
      check(ok, {"R3 R4 R5 R6 R10 cell ", tag}, {oe, dp, dm}, {1'b1, exp_lvl[i], !exp_lvl[i]});
    end
    start = 1'b0;
    ok = 1'b1;
    for (int c = 0; c < 2*B; c++) begin @(negedge clk); if (!(oe && !dp && !dm)) ok = 1'b0; end
    check(ok, {"R7 SE0 ", tag}, {oe, dp, dm}, 3'b100);
    ok = 1'b1;
    for (int c = 0; c < B; c++) begin @(negedge clk); if (!(oe && !dp && dm)) ok = 1'b0; end
    check(ok, {"R7 J ", tag}, {oe, dp, dm}, 3'b101);
    @(negedge clk);
    check(!oe && done, {"R8 release with done ", tag}, {oe, done}, 2'b01);
    ok = 1'b1;
    for (int c = 0; c < 2*B; c++) begin @(negedge clk); if (oe || done) ok = 1'b0; end
    check(ok, {"R8 R9 quiet after ", tag}, {oe, done}, 2'b00);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(!oe && !done && !dp && dm, "R1 in reset", {oe, done, dp, dm}, 4'b0001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!oe && !done && !dp && dm, "R1 idle after reset", {oe, done, dp, dm}, 4'b0001);
    for (int v = 0; v < 6; v++)
      run_case(int'(VEC[v][39:32]), VEC[v][31:0], 1'b0, $sformatf("vec%0d", v));
    run_case(2, 32'hFFFF_0000, 1'b1, "R9 busy start");
    run_case(0, 32'h0, 1'b0, "R10 sync only");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule